// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a small synchronous single-port memory. Its inputs are sampled on the rising clock edge and its read data leaves through an output register. An access begins with one of two active-low address strobes. The processor strobe is honoured only while the first chip select is active. The controller strobe is honoured under any chip-select combination. Three chip selects decide whether a strobe starts an access or deselects the block. While an access is open, cycles with neither strobe continue it. An advance input steps a two-bit wrapping burst counter, in linear or interleaved order as a static mode input selects.

Writes merge byte lanes. A global write enable writes every lane. Otherwise a byte enable together with per-lane selects picks the lanes to write. A write opened by the controller strobe takes its write controls in the address cycle. A write opened by the processor strobe takes two cycles: the first cycle ignores the write and advance inputs, and the second cycle performs the write. Read data is driven only while the asynchronous output enable is low and the output register holds valid read data. The drive enable stands for the three-state control of the data bus.

Top module: `pbsram_core`

## Requirements
- R1: A read starts at an edge where a strobe is accepted, all chip selects are active (ce1_n low, ce2 high, ce3_n low), and gw_n and bwe_n are both high. Its data is on q_out, with q_en high, after the following clock edge, provided oe_n is low.
- R2: While ce1_n is high, adsp_n has no effect. With adsc_n high, that cycle continues the open access as if no strobe were present.
- R3: A controller-strobe access with all chip selects active writes d_in to the sampled address at the same edge when gw_n or bwe_n is low.
- R4: A processor-strobe start ignores gw_n, bwe_n, bw_n and adv_n. A write in the next cycle, with no strobe, stores d_in at the loaded address.
- R5: A low gw_n writes every byte lane, whatever bwe_n and bw_n are.
- R6: With gw_n high and bwe_n low, byte lane i (bits 8i+7..8i) is written only when bw_n[i] is low. The other lanes keep their contents.
- R7: When an access starts from the deselected state, q_en is low for the first cycle after the start edge. From then on only oe_n controls it.
- R8: A strobe at an edge where a qualifying chip select is inactive makes q_en low right after that edge. For adsp_n this means ce1_n low but ce2 low or ce3_n high. For adsc_n it means any chip select inactive.
- R9: oe_n high forces q_en low without waiting for a clock edge. Returning oe_n low restores the drive.
- R10: With burst_lin high, each continuation cycle with adv_n low moves to address {base[AW-1:2], base[1:0]+n}, where n is the beat count modulo 4.
- R11: With burst_lin low, beat n uses address {base[AW-1:2], base[1:0]^n}.
- R12: Reads started on consecutive clocks are each returned one clock after their address edge, one per clock.
- R13: When both strobes are low with ce1_n low, the processor strobe wins, so the write controls of that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low, also gates adsp_n |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | NB | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 8*NB | Write data |
| q_out | output | 8*NB | Read data, zero when not driven |
| q_en | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with AW=6 and NB=2, which gives a 64-word array of two byte lanes. At that size the bench writes and reads back every word, once with one read accepted per clock. It also tries all four lane-select masks, and all four burst start offsets in both burst orders, which covers every wrap of the counter. The bench also walks each deselect path of both strobes and the ignored-strobe cases, and checks q_en right after the edge.

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_lin,
  input  logic [AW-1:0]   addr,
  input  logic            adsp_n,
  input  logic            adsc_n,
  input  logic            adv_n,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [NB-1:0]   bw_n,
  input  logic            oe_n,
  input  logic [8*NB-1:0] d_in,
  output logic [8*NB-1:0] q_out,
  output logic            q_en
);
  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          active, rd_pend, q_vld;
  logic [AW-1:0] base, rd_addr;
  logic [1:0]    cnt;
  logic [DW-1:0] q_reg;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] n, input logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + n) : (b[1:0] ^ n);
    return {b[AW-1:2], lo};
  endfunction

  wire sel    = !ce1_n && ce2 && !ce3_n;
  wire p_hit  = !adsp_n && !ce1_n;
  wire c_hit  = !p_hit && !adsc_n;
  wire strobe = p_hit || c_hit;
  wire start  = strobe && sel;
  wire dsel   = strobe && !sel;
  wire cont   = !strobe && active;
  wire is_wr  = !gw_n || !bwe_n;
  wire do_wr  = (c_hit && sel && is_wr) || (cont && is_wr);
  wire do_rd  = (p_hit && sel) || (c_hit && sel && !is_wr) || (cont && !is_wr);

  wire [AW-1:0] cont_addr = beat_addr(base, adv_n ? cnt : cnt + 2'd1, burst_lin);
  wire [AW-1:0] acc_addr  = start ? addr : cont_addr;
  wire [NB-1:0] lane_we   = !gw_n ? {NB{1'b1}} : (!bwe_n ? ~bw_n : {NB{1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      q_reg   <= '0;
      q_vld   <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1;
        base   <= addr;
        cnt    <= '0;
      end else if (dsel) begin
        active <= 1'b0;
      end else if (cont && !adv_n) begin
        cnt <= cnt + 2'd1;
      end
      rd_pend <= do_rd;
      rd_addr <= acc_addr;
      q_reg   <= mem[rd_addr];
      q_vld   <= dsel ? 1'b0 : rd_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int i = 0; i < NB; i++) begin
        if (lane_we[i]) mem[acc_addr][8*i +: 8] <= d_in[8*i +: 8];
      end
    end
  end

  assign q_en  = q_vld && !oe_n;
  assign q_out = q_en ? q_reg : '0;

  a_r8_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    dsel |=> !q_en);
  a_r7_first_cycle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> !q_vld);
  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !dsel) |=> q_vld);
  a_r10_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !adv_n) |=> (cnt == $past(cnt) + 2'd1));
  a_r4_second_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hit && sel) ##1 (cont && !gw_n) |-> (do_wr && lane_we == {NB{1'b1}}));
endmodule

// File: tb/pbsram_core_tb_top.sv
`timescale 1ns/1ps
module pbsram_core_tb_top;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_lin = 1'b1;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic q_en;

  logic [DW-1:0] exp_mem [DEPTH];
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pbsram_core #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_lin(burst_lin), .addr(addr),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .d_in(d_in), .q_out(q_out), .q_en(q_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic idle_in();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 16'h0331) ^ (salt * 16'h5A17) ^ 16'hC3A5);
  endfunction

  task automatic rd_start(input logic [AW-1:0] a);
    idle_in(); adsc_n = 0; addr = a; tick();
  endtask

  task automatic rd_check(input string tag, input logic [AW-1:0] a);
    rd_start(a);
    idle_in(); tick();
    chk({tag, " q_en"}, 32'(q_en), 32'd1);
    chk({tag, " data"}, 32'(q_out), 32'(exp_mem[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_in();
    repeat (3) tick();
    chk("reset q_en", 32'(q_en), 32'd0);
    chk("reset q_out", 32'(q_out), 32'd0);
    rst_n = 1;
    tick();

    // R3: fill every word with controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); adsc_n = 0; addr = AW'(a); gw_n = 0; d_in = pat(a, 1);
      exp_mem[a] = pat(a, 1);
      tick();
      chk("R3 no drive during write", 32'(q_en), 32'd0);
    end

    // R12 / R1: back-to-back reads across the array
    rd_start('0);
    for (int a = 1; a < DEPTH; a++) begin
      idle_in(); adsc_n = 0; addr = AW'(a); tick();
      chk("R12 pipelined data", 32'(q_out), 32'(exp_mem[a-1]));
      chk("R1 drive on", 32'(q_en), 32'd1);
    end
    idle_in(); tick();
    chk("R12 last data", 32'(q_out), 32'(exp_mem[DEPTH-1]));

    // R6: all lane masks with byte write enable
    for (int m = 0; m < 4; m++) begin
      idle_in(); adsc_n = 0; addr = AW'(20 + m); bwe_n = 0; bw_n = ~NB'(m);
      d_in = pat(m, 7);
      for (int l = 0; l < NB; l++)
        if (m[l]) exp_mem[20+m][8*l +: 8] = d_in[8*l +: 8];
      tick();
    end
    for (int m = 0; m < 4; m++) rd_check("R6 lane merge", AW'(20 + m));

    // R5: global write overrides deselected lanes
    idle_in(); adsc_n = 0; addr = 6'd30; gw_n = 0; bwe_n = 0; bw_n = '1;
    d_in = 16'hBEEF; exp_mem[30] = 16'hBEEF; tick();
    rd_check("R5 global write", 6'd30);

    // R4: two-cycle processor-strobe write, first cycle controls ignored
    idle_in(); adsp_n = 0; addr = 6'd33; gw_n = 0; adv_n = 0; d_in = 16'h1111; tick();
    idle_in(); gw_n = 0; d_in = 16'h2222; exp_mem[33] = 16'h2222; tick();
    rd_check("R4 second cycle write", 6'd33);
    rd_check("R4 neighbour untouched", 6'd34);

    // R13: both strobes low, processor strobe wins and write is ignored
    idle_in(); adsp_n = 0; adsc_n = 0; addr = 6'd40; gw_n = 0; d_in = 16'h7777; tick();
    idle_in(); tick();
    chk("R13 read of priority strobe", 32'(q_out), 32'(exp_mem[40]));
    rd_check("R13 no write", 6'd40);

    // R2: processor strobe ignored while ce1_n high
    rd_start(6'd10);
    idle_in(); ce1_n = 1; adsp_n = 0; addr = 6'd11; tick();
    idle_in(); tick();
    chk("R2 still driving", 32'(q_en), 32'd1);
    chk("R2 old access kept", 32'(q_out), 32'(exp_mem[10]));

    // R9: asynchronous output enable
    oe_n = 1; #1;
    chk("R9 oe off", 32'(q_en), 32'd0);
    oe_n = 0; #1;
    chk("R9 oe on", 32'(q_en), 32'd1);
    chk("R9 data back", 32'(q_out), 32'(exp_mem[10]));

    // R8: controller strobe with ce2 low deselects
    idle_in(); adsc_n = 0; ce2 = 0; tick();
    chk("R8 adsc deselect", 32'(q_en), 32'd0);
    // R7: first cycle after deselect stays off
    rd_start(6'd12);
    chk("R7 first cycle off", 32'(q_en), 32'd0);
    idle_in(); tick();
    chk("R7 then on", 32'(q_en), 32'd1);
    chk("R7 data", 32'(q_out), 32'(exp_mem[12]));
    // R8: processor strobe with ce3_n high deselects
    idle_in(); adsp_n = 0; ce3_n = 1; tick();
    chk("R8 adsp deselect", 32'(q_en), 32'd0);
    idle_in(); tick();
    chk("R8 stays off", 32'(q_en), 32'd0);

    // R10 / R11: every start offset in both burst orders
    for (int md = 0; md < 2; md++) begin
      burst_lin = md[0];
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] bs;
        bs = AW'(44 + b);
        rd_start(bs);
        for (int j = 0; j < 4; j++) begin
          logic [1:0] lo;
          lo = md[0] ? (bs[1:0] + 2'(j)) : (bs[1:0] ^ 2'(j));
          idle_in(); adv_n = (j < 3) ? 1'b0 : 1'b1; tick();
          chk(md[0] ? "R10 linear beat" : "R11 interleaved beat",
              32'(q_out), 32'(exp_mem[{bs[AW-1:2], lo}]));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule